// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block holds four independent down-counters reached through a plain 32-bit register bus (byte address, write enable, write data, combinational read data). Each counter owns a load register, a read-only view of its current count, a control word and a deferred-reload register. The deferred-reload register lets software change the next period without touching the count in progress. All counters share one interrupt section: a mask, the raw event bits, the masked view and a write-one-to-clear register. One combined interrupt line leaves the block.

The block runs on a single clock. A `tick_en` input marks the clock cycles in which time advances. Each counter divides those ticks by 1, 16 or 256 before it decrements. A counter can run one-shot, periodic (reloading from its deferred-reload value) or free-running (wrapping to all-ones), and it counts over 16 or 32 bits.

Top module: `quad_dntimer`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: A counter whose control bit 7 is set decreases by one on each prescaled tick. With bit 7 clear, its count holds.
- R3: Control bits 3:2 choose the tick divider: 00 divides by 1, 01 by 16, and 10 or 11 by 256. The divider returns to zero while the counter is disabled, so a partial count is not carried across a disable.
- R4: A write to the load register (channel offset +0x0) sets the count and the deferred-reload register to the written value. The load register reads back that value.
- R5: A write to the deferred-reload register (channel offset +0xC) leaves the running count unchanged. The new value is used at the next underflow.
- R6: In periodic mode (bit 6 set, bit 0 clear), a prescaled tick at count zero reloads the count from the deferred-reload value and sets the counter's raw interrupt bit.
- R7: In free-running mode (bits 6 and 0 clear), a tick at zero wraps the count to all-ones and sets the raw bit. Bit 1 selects 32-bit counting. With bit 1 clear, the count and its readout use only the low 16 bits.
- R8: In one-shot mode (bit 0 set, which overrides bit 6), the counter decrements to zero and sets its raw bit on reaching zero. It then holds at zero.
- R9: Writing 1 to bit n at offset 0x0C clears raw bit n. A 0 bit leaves its raw bit alone. The clear offset reads as zero.
- R10: Offset 0x08 reads raw AND mask, where the mask is read/write at 0x00. `irq_out` is high exactly when any masked bit is set.
- R11: Raw status is at 0x04. Counter n uses base 0x10+0x10*n, with the current value at +0x4 and control at +0x8. Writes to the status, masked-status and current-value offsets are ignored. Unaligned or unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Time-advance strobe, one clock wide per tick |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | OR of all masked interrupt bits |

## Verification
The counters are driven with bursts of a known number of ticks. The counts are then read back at three divider settings. Tick totals just below and just above 16 and 256 tell a correct divide ratio from an off-by-one, and a disable between two short bursts shows whether the divider was cleared. Underflow is tested in each mode. The periodic case changes the deferred-reload value before reaching zero, so a stale reload or a disturbed count shows up. The free-running case is run at both widths, and the one-shot case keeps ticking after zero. Interrupt tests clear a bit that is not set and then the bit that is, toggle the mask, and write to read-only and unmapped offsets.

// File: rtl/qtim_pkg.sv
package qtim_pkg;

    localparam int DATA_W = 32;

    // shared register word offsets (address bits 3:2 inside block 0)
    localparam logic [1:0] SH_MASK  = 2'd0;
    localparam logic [1:0] SH_RAW   = 2'd1;
    localparam logic [1:0] SH_MIS   = 2'd2;
    localparam logic [1:0] SH_CLR   = 2'd3;

    // per-channel word offsets
    localparam logic [1:0] CH_LOAD  = 2'd0;
    localparam logic [1:0] CH_VALUE = 2'd1;
    localparam logic [1:0] CH_CTRL  = 2'd2;
    localparam logic [1:0] CH_BG    = 2'd3;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'b00,
        PSC_DIV16  = 2'b01,
        PSC_DIV256 = 2'b10,
        PSC_ALT256 = 2'b11
    } psc_e;

    typedef struct packed {
        logic en;
        logic periodic;
        psc_e psc;
        logic wide;
        logic oneshot;
    } ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] load;
        logic [DATA_W-1:0] bg;
        ctrl_t             ctrl;
    } chan_st_t;

    function automatic ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.en       = w[7];
        c.periodic = w[6];
        c.psc      = psc_e'(w[3:2]);
        c.wide     = w[1];
        c.oneshot  = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w      = '0;
        w[7]   = c.en;
        w[6]   = c.periodic;
        w[3:2] = c.psc;
        w[1]   = c.wide;
        w[0]   = c.oneshot;
        return w;
    endfunction

endpackage

// File: rtl/qtim_prescaler.sv
module qtim_prescaler
    import qtim_pkg::*;
#(
    parameter int DIV16_LOG  = 4,
    parameter int DIV256_LOG = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick_en,
    input  psc_e psc,
    output logic step_o
);
    localparam int PRE_W = DIV256_LOG;
    localparam logic [PRE_W-1:0] LIM16 = PRE_W'((1 << DIV16_LOG) - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        case (psc)
            PSC_DIV1:  lim = '0;
            PSC_DIV16: lim = LIM16;
            default:   lim = '1;
        endcase
        pre_d = pre_q;
        if (!enable)
            pre_d = '0;
        else if (tick_en)
            pre_d = pre_q + 1'b1;
        step_o = enable && tick_en && ((pre_q & lim) == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3: divider is cleared while its counter is off
    a_r3_div_clears_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> pre_q == '0);

endmodule

// File: rtl/qtim_channel.sv
module qtim_channel
    import qtim_pkg::*;
#(
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ld_we,
    input  logic              bg_we,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] bg_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              evt_o
);
    localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    chan_st_t          st_d, st_q;
    logic              step;
    logic [DATA_W-1:0] wmask, cur;

    qtim_prescaler u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (st_q.ctrl.en),
        .tick_en (tick_en),
        .psc     (st_q.ctrl.psc),
        .step_o  (step)
    );

    always_comb begin
        st_d  = st_q;
        evt_o = 1'b0;
        wmask = st_q.ctrl.wide ? '1 : NARROW_MASK;
        cur   = st_q.cnt & wmask;
        if (step) begin
            if (st_q.ctrl.oneshot) begin
                if (cur != '0) begin
                    st_d.cnt = cur - 1'b1;
                    evt_o    = (cur == DATA_W'(1));
                end
            end else if (cur == '0) begin
                evt_o    = 1'b1;
                st_d.cnt = st_q.ctrl.periodic ? st_q.bg : wmask;
            end else begin
                st_d.cnt = cur - 1'b1;
            end
        end
        if (ctrl_we) st_d.ctrl = ctrl_unpack(wdata);
        if (bg_we)   st_d.bg   = wdata;
        if (ld_we) begin
            st_d.load = wdata;
            st_d.bg   = wdata;
            st_d.cnt  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = cur;
    assign load_o = st_q.load;
    assign bg_o   = st_q.bg;
    assign ctrl_o = ctrl_pack(st_q.ctrl);

    // R2: a disabled counter keeps its count
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !ld_we) |=> $stable(st_q.cnt));

    // R4: load write reaches count and deferred-reload register
    a_r4_load_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (st_q.cnt == $past(wdata)) && (st_q.bg == $past(wdata)));

    // R5: deferred-reload write does not move the count
    a_r5_bg_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_we && !ld_we && !step) |=> $stable(st_q.cnt));

    // R8: one-shot counter rests at zero
    a_r8_oneshot_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.oneshot && val_o == '0 && !ld_we && !ctrl_we) |=> val_o == '0);

endmodule

// File: rtl/qtim_irq.sv
module qtim_irq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mask_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] evt,
    output logic [NCH-1:0] mask_o,
    output logic [NCH-1:0] raw_o,
    output logic [NCH-1:0] mis_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [NCH-1:0] mask;
        logic [NCH-1:0] raw;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = wdata;
        // a new event wins over a clear in the same cycle
        st_d.raw = (st_q.raw & ~(clr_we ? wdata : '0)) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
    assign raw_o  = st_q.raw;
    assign mis_o  = st_q.raw & st_q.mask;
    assign irq_o  = |mis_o;

    // R9: cleared bits drop unless re-set by an event
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (st_q.raw & $past(wdata & ~evt)) == '0);

    // R6: an event always lands in raw status
    a_r6_event_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q.raw & $past(evt)) == $past(evt)));

endmodule

// File: rtl/quad_dntimer.sv
module quad_dntimer
    import qtim_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int ADDR_W   = 8,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] blk;
    logic [1:0]       word;
    logic             aligned, sh_sel;

    logic [NCH-1:0]    evt, irq_mask, irq_raw, irq_mis;
    logic [DATA_W-1:0] ch_val  [NCH];
    logic [DATA_W-1:0] ch_load [NCH];
    logic [DATA_W-1:0] ch_bg   [NCH];
    logic [DATA_W-1:0] ch_ctrl [NCH];

    assign blk     = bus_addr[ADDR_W-1:4];
    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sh_sel  = aligned && (blk == '0);

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic sel;
        assign sel = aligned && (blk == IDX_W'(n + 1));

        qtim_channel #(.NARROW_W(NARROW_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .ld_we   (bus_we && sel && word == CH_LOAD),
            .bg_we   (bus_we && sel && word == CH_BG),
            .ctrl_we (bus_we && sel && word == CH_CTRL),
            .wdata   (bus_wdata),
            .val_o   (ch_val[n]),
            .load_o  (ch_load[n]),
            .bg_o    (ch_bg[n]),
            .ctrl_o  (ch_ctrl[n]),
            .evt_o   (evt[n])
        );
    end

    qtim_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (bus_we && sh_sel && word == SH_MASK),
        .clr_we  (bus_we && sh_sel && word == SH_CLR),
        .wdata   (bus_wdata[NCH-1:0]),
        .evt     (evt),
        .mask_o  (irq_mask),
        .raw_o   (irq_raw),
        .mis_o   (irq_mis),
        .irq_o   (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (sh_sel) begin
            case (word)
                SH_MASK: bus_rdata = {{(DATA_W-NCH){1'b0}}, irq_mask};
                SH_RAW:  bus_rdata = {{(DATA_W-NCH){1'b0}}, irq_raw};
                SH_MIS:  bus_rdata = {{(DATA_W-NCH){1'b0}}, irq_mis};
                default: bus_rdata = '0;
            endcase
        end
        for (int c = 0; c < NCH; c++) begin
            if (aligned && blk == IDX_W'(c + 1)) begin
                case (word)
                    CH_LOAD:  bus_rdata = ch_load[c];
                    CH_VALUE: bus_rdata = ch_val[c];
                    CH_CTRL:  bus_rdata = ch_ctrl[c];
                    default:  bus_rdata = ch_bg[c];
                endcase
            end
        end
    end

    // R10: combined line follows masked status
    a_r10_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_raw & irq_mask) != '0);

endmodule

// File: tb/quad_dntimer_tb.sv
module quad_dntimer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    quad_dntimer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [7:0] chb(input int n);
        return 8'(8'h10 + 8'h10 * n);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 mask", 8'h00, 0);
        rd_chk("R1 raw", 8'h04, 0);
        rd_chk("R1 ch0 value", chb(0) + 8'h4, 0);
        rd_chk("R1 ch3 ctrl", chb(3) + 8'h8, 0);
        chk("R1 irq_out", {31'b0, irq_out}, 0);
    endtask

    task automatic t_count_div1;
        wr(chb(0), 100);
        chk("R4 load readback", 0, 0);
        rd_chk("R4 load readback", chb(0), 100);
        rd_chk("R4 bg follows load", chb(0) + 8'hC, 100);
        wr(chb(0) + 8'h8, 32'h82);
        ticks(10);
        rd_chk("R2 div1 after 10", chb(0) + 8'h4, 90);
        wr(chb(0) + 8'h8, 32'h02);
        ticks(5);
        rd_chk("R2 disabled holds", chb(0) + 8'h4, 90);
    endtask

    task automatic t_prescale;
        wr(chb(0), 100);
        wr(chb(0) + 8'h8, 32'h86);
        ticks(47);
        rd_chk("R3 div16 47 ticks", chb(0) + 8'h4, 98);
        ticks(1);
        rd_chk("R3 div16 48 ticks", chb(0) + 8'h4, 97);
        wr(chb(0) + 8'h8, 32'h06);
        wr(chb(0), 100);
        wr(chb(0) + 8'h8, 32'h86);
        ticks(10);
        wr(chb(0) + 8'h8, 32'h06);
        wr(chb(0) + 8'h8, 32'h86);
        ticks(10);
        rd_chk("R3 divider cleared on disable", chb(0) + 8'h4, 100);
        wr(chb(0) + 8'h8, 32'h0A);
        wr(chb(0), 50);
        wr(chb(0) + 8'h8, 32'h8A);
        ticks(255);
        rd_chk("R3 div256 255 ticks", chb(0) + 8'h4, 50);
        ticks(1);
        rd_chk("R3 div256 256 ticks", chb(0) + 8'h4, 49);
        wr(chb(0) + 8'h8, 32'h02);
    endtask

    task automatic t_periodic;
        wr(8'h0C, 32'hF);
        wr(chb(1), 3);
        wr(chb(1) + 8'hC, 10);
        rd_chk("R5 bg write keeps count", chb(1) + 8'h4, 3);
        wr(chb(1) + 8'h8, 32'hC2);
        ticks(3);
        rd_chk("R6 reaches zero", chb(1) + 8'h4, 0);
        rd_chk("R6 no event yet", 8'h04, 0);
        ticks(1);
        rd_chk("R5 reload from new bg", chb(1) + 8'h4, 10);
        rd_chk("R6 raw bit1", 8'h04, 32'h2);
        ticks(2);
        rd_chk("R6 counts after reload", chb(1) + 8'h4, 8);
        wr(chb(1) + 8'h8, 32'h42);
    endtask

    task automatic t_free;
        wr(8'h0C, 32'hF);
        wr(chb(2), 1);
        wr(chb(2) + 8'h8, 32'h80);
        ticks(2);
        rd_chk("R7 16-bit wrap", chb(2) + 8'h4, 32'h0000FFFF);
        rd_chk("R7 raw bit2", 8'h04, 32'h4);
        wr(chb(2) + 8'h8, 32'h00);
        wr(chb(2), 32'h12345);
        rd_chk("R7 16-bit view truncates", chb(2) + 8'h4, 32'h2345);
        wr(chb(3), 0);
        wr(chb(3) + 8'h8, 32'h82);
        ticks(1);
        rd_chk("R7 32-bit wrap", chb(3) + 8'h4, 32'hFFFFFFFF);
        wr(chb(3) + 8'h8, 32'h02);
    endtask

    task automatic t_oneshot;
        wr(8'h0C, 32'hF);
        wr(chb(0), 2);
        wr(chb(0) + 8'h8, 32'hC3);
        ticks(1);
        rd_chk("R8 no event at 1", 8'h04, 0);
        ticks(1);
        rd_chk("R8 reaches zero", chb(0) + 8'h4, 0);
        rd_chk("R8 raw bit0", 8'h04, 32'h1);
        wr(8'h0C, 32'h1);
        ticks(5);
        rd_chk("R8 holds at zero", chb(0) + 8'h4, 0);
        rd_chk("R8 no further event", 8'h04, 0);
    endtask

    task automatic t_irq;
        wr(8'h0C, 32'hF);
        wr(8'h00, 32'h0);
        wr(chb(0), 1);
        ticks(1);
        rd_chk("R10 raw set", 8'h04, 32'h1);
        rd_chk("R10 masked off", 8'h08, 0);
        chk("R10 irq low when masked", {31'b0, irq_out}, 0);
        wr(8'h00, 32'h1);
        rd_chk("R10 mask readback", 8'h00, 32'h1);
        rd_chk("R10 masked on", 8'h08, 32'h1);
        chk("R10 irq high", {31'b0, irq_out}, 1);
        wr(8'h0C, 32'h2);
        rd_chk("R9 other bit clear no effect", 8'h04, 32'h1);
        wr(8'h0C, 32'h1);
        rd_chk("R9 clear drops raw", 8'h04, 0);
        chk("R9 irq drops", {31'b0, irq_out}, 0);
        rd_chk("R9 clear reads zero", 8'h0C, 0);
    endtask

    task automatic t_map;
        wr(8'h04, 32'hF);
        rd_chk("R11 raw write ignored", 8'h04, 0);
        wr(8'h08, 32'hF);
        rd_chk("R11 masked write ignored", 8'h08, 0);
        wr(chb(0) + 8'h4, 32'h55);
        rd_chk("R11 value write ignored", chb(0) + 8'h4, 0);
        rd_chk("R11 unmapped 0x50", 8'h50, 0);
        rd_chk("R11 unmapped 0x80", 8'h80, 0);
        rd_chk("R11 unaligned", chb(1) + 8'h1, 0);
        rd_chk("R11 ctrl readback", chb(1) + 8'h8, 32'h42);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count_div1();
        t_prescale();
        t_periodic();
        t_free();
        t_oneshot();
        t_irq();
        t_map();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule